// File: doc/BRIEF.md
# Write Protection Command Sequencer

This block sits beside the byte-load path of a paged non-volatile memory. It watches every byte written on the bus (a 15-bit address and 8-bit data). It recognises short address/data handshakes that switch a protect flag on or off. The same handshake is also used as a key that authorises one page load while protection is on. The block decides, in the cycle of each write, whether the byte is passed on to the page buffer, consumed as a command byte, or rejected. A rejected byte starts the write timer, so a host that polls for completion behaves as if a write took place.

A change to the protect flag is only staged when a sequence completes. It takes effect when the write period ends, which the surrounding logic signals with an end-of-write pulse. That end can come after a page of data or with no data at all. The protect flag has its own clear input. The sequencer reset leaves the flag untouched, so the flag models a setting that survives power cycles.

Top module: `wp_cmd_sequencer`

## Requirements
- R1: After the clear input and the sequencer reset, protOn is 0, and with no write present dataPass and timerStart are 0.
- R2: While unprotected, a write whose first byte is not data 0xAA at address 0x5555 is passed in its own cycle (dataPass=1, timerStart=0), and later bytes of the same load are passed too.
- R3: The three-byte key (0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555) is consumed with dataPass=0. protOn stays unchanged until the end-of-write pulse that follows the byte-load timeout, and reads 1 from the cycle after that pulse.
- R4: The three-byte key followed only by a timeout and an end-of-write pulse, with no data bytes, still sets protOn.
- R5: While protected, a write that does not start the key gets dataPass=0 and timerStart=1 in its cycle. Further writes are then ignored (both outputs 0) until the end-of-write pulse.
- R6: While protected, data bytes after the three-byte key are passed (1 to 64 bytes, checked at 64), and protOn stays 1.
- R7: The six-byte release sequence (0xAA to 0x5555, 0x55 to 0x2AAA, 0x80 to 0x5555, 0xAA to 0x5555, 0x55 to 0x2AAA, 0x20 to 0x5555) is consumed. Data bytes after it are passed, and protOn reads 0 from the cycle after the end-of-write pulse.
- R8: While protected, a byte that breaks a partly entered sequence is not passed and raises timerStart in its cycle.
- R9: While unprotected, a byte that breaks a partly entered sequence is passed as a normal write. The bytes consumed before it are not passed.
- R10: A byte-load timeout during a partly entered sequence discards it, so the next byte is judged as the first byte of a new access.
- R11: The sequencer reset does not change protOn. Only the clear input forces it to 0, one cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the sequencer and staged change |
| protClr | input | 1 | Synchronous clear of the protect flag (initialisation only) |
| wrValid | input | 1 | A byte write is present this cycle |
| wrAddr | input | 15 | Byte address of the write |
| wrData | input | 8 | Byte data of the write |
| loadTimeout | input | 1 | Byte-load window expired; page load closes |
| writeDone | input | 1 | End-of-write pulse from the write timer |
| protOn | output | 1 | Protect flag |
| dataPass | output | 1 | Current write is forwarded to the page buffer |
| timerStart | output | 1 | Current write is rejected and starts the write timer |

## Verification
The assertions assume that wrValid, loadTimeout and writeDone are never raised in the same cycle, since the block gives timeout priority over a coincident write. They also assume that writeDone only arrives after the timer was started by a timeout or a rejected write. The stimulus drives at most one of these events per cycle. It raises writeDone only after a timeout or a rejection, and it raises protClr only during initialisation and in the one directed check of the clear path.

// File: rtl/wp_cmd_sequencer_pkg.sv
package wp_cmd_sequencer_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_KEY1,
    S_KEY2,
    S_REL3,
    S_REL4,
    S_REL5,
    S_LOAD,
    S_BUSY
  } seq_state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic armSet;
    logic armClr;
    logic commit;
  } dp_strobe_t;

  // datapath -> control pattern hits
  typedef struct packed {
    logic keyA;
    logic keyB;
    logic lockCode;
    logic relCode;
    logic freeCode;
  } pat_hit_t;

  localparam int NUM_PAT = 5;

endpackage

// File: rtl/wp_cmd_datapath.sv
module wp_cmd_datapath
  import wp_cmd_sequencer_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_HI = 15'h5555,
  parameter logic [ADDR_W-1:0] ADDR_LO = 15'h2AAA,
  parameter logic [DATA_W-1:0] KEY_A = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_B = 8'h55,
  parameter logic [DATA_W-1:0] CODE_LOCK = 8'hA0,
  parameter logic [DATA_W-1:0] CODE_REL = 8'h80,
  parameter logic [DATA_W-1:0] CODE_FREE = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              protClr,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  dp_strobe_t        strobe,
  output pat_hit_t          hits,
  output logic              protOn
);

  localparam logic [ADDR_W-1:0] PAT_ADDR [NUM_PAT] =
    '{ADDR_HI, ADDR_LO, ADDR_HI, ADDR_HI, ADDR_HI};
  localparam logic [DATA_W-1:0] PAT_DATA [NUM_PAT] =
    '{KEY_A, KEY_B, CODE_LOCK, CODE_REL, CODE_FREE};

  logic [NUM_PAT-1:0] hitVec;
  logic pendValid;
  logic pendVal;

  for (genvar gi = 0; gi < NUM_PAT; gi++) begin : g_pat
    assign hitVec[gi] = (wrAddr == PAT_ADDR[gi]) && (wrData == PAT_DATA[gi]);
  end

  assign hits.keyA     = hitVec[0];
  assign hits.keyB     = hitVec[1];
  assign hits.lockCode = hitVec[2];
  assign hits.relCode  = hitVec[3];
  assign hits.freeCode = hitVec[4];

  // staged change of the protect flag, applied at end of write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendVal   <= 1'b0;
    end else if (strobe.armSet) begin
      pendValid <= 1'b1;
      pendVal   <= 1'b1;
    end else if (strobe.armClr) begin
      pendValid <= 1'b1;
      pendVal   <= 1'b0;
    end else if (strobe.commit) begin
      pendValid <= 1'b0;
    end
  end

  // protect flag: untouched by rstN, cleared only by protClr
  always_ff @(posedge clk) begin
    if (protClr) begin
      protOn <= 1'b0;
    end else if (strobe.commit && pendValid) begin
      protOn <= pendVal;
    end
  end

endmodule

// File: rtl/wp_cmd_ctrl.sv
module wp_cmd_ctrl
  import wp_cmd_sequencer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic       loadTimeout,
  input  logic       writeDone,
  input  pat_hit_t   hits,
  input  logic       protOn,
  output dp_strobe_t strobe,
  output logic       dataPass,
  output logic       timerStart
);

  seq_state_e state, nextState;
  logic abortNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState  = state;
    strobe     = '0;
    dataPass   = 1'b0;
    timerStart = 1'b0;
    abortNow   = 1'b0;

    if (loadTimeout) begin
      unique case (state)
        S_KEY1, S_KEY2, S_REL3, S_REL4, S_REL5: nextState = S_IDLE;
        S_LOAD:  nextState = S_BUSY;
        default: nextState = state;
      endcase
    end else if (writeDone) begin
      if (state == S_BUSY) begin
        strobe.commit = 1'b1;
        nextState     = S_IDLE;
      end
    end else if (wrValid) begin
      unique case (state)
        S_IDLE: begin
          if (hits.keyA) nextState = S_KEY1;
          else           abortNow  = 1'b1;
        end
        S_KEY1: begin
          if (hits.keyB) nextState = S_KEY2;
          else           abortNow  = 1'b1;
        end
        S_KEY2: begin
          if (hits.lockCode) begin
            strobe.armSet = 1'b1;
            nextState     = S_LOAD;
          end else if (hits.relCode) begin
            nextState = S_REL3;
          end else begin
            abortNow = 1'b1;
          end
        end
        S_REL3: begin
          if (hits.keyA) nextState = S_REL4;
          else           abortNow  = 1'b1;
        end
        S_REL4: begin
          if (hits.keyB) nextState = S_REL5;
          else           abortNow  = 1'b1;
        end
        S_REL5: begin
          if (hits.freeCode) begin
            strobe.armClr = 1'b1;
            nextState     = S_LOAD;
          end else begin
            abortNow = 1'b1;
          end
        end
        S_LOAD:  dataPass  = 1'b1;
        default: nextState = state;
      endcase

      if (abortNow) begin
        if (protOn) begin
          timerStart = 1'b1;
          nextState  = S_BUSY;
        end else begin
          dataPass  = 1'b1;
          nextState = S_LOAD;
        end
      end
    end
  end

endmodule

// File: rtl/wp_cmd_sequencer.sv
module wp_cmd_sequencer
  import wp_cmd_sequencer_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              protClr,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              loadTimeout,
  input  logic              writeDone,
  output logic              protOn,
  output logic              dataPass,
  output logic              timerStart
);

  dp_strobe_t strobe;
  pat_hit_t   hits;

  wp_cmd_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .wrValid    (wrValid),
    .loadTimeout(loadTimeout),
    .writeDone  (writeDone),
    .hits       (hits),
    .protOn     (protOn),
    .strobe     (strobe),
    .dataPass   (dataPass),
    .timerStart (timerStart)
  );

  wp_cmd_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .protClr(protClr),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .strobe (strobe),
    .hits   (hits),
    .protOn (protOn)
  );

endmodule

// File: rtl/wp_cmd_sequencer_chk.sv
module wp_cmd_sequencer_chk (
  input logic clk,
  input logic rstN,
  input logic protClr,
  input logic wrValid,
  input logic writeDone,
  input logic protOn,
  input logic dataPass,
  input logic timerStart
);

  // R2 / R5: an output decision needs a write in the same cycle
  p_decision_needs_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dataPass || timerStart) |-> wrValid);

  // R5: a byte is never both forwarded and rejected
  p_pass_excl_reject_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(dataPass && timerStart));

  // R5: after a rejection the next cycle is quiet
  p_reject_then_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    timerStart |=> !timerStart);

  // R8: rejection only while protected
  p_reject_only_protected_r8: assert property (@(posedge clk) disable iff (!rstN)
    timerStart |-> protOn);

  // R3 / R7: the flag moves only after an end-of-write pulse or a clear
  p_flag_moves_at_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    (protOn != $past(protOn)) |-> ($past(writeDone) || $past(protClr)));

  // R11: clear forces the flag off in the next cycle
  p_clear_forces_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    protClr |=> !protOn);

endmodule

bind wp_cmd_sequencer wp_cmd_sequencer_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .protClr   (protClr),
  .wrValid   (wrValid),
  .writeDone (writeDone),
  .protOn    (protOn),
  .dataPass  (dataPass),
  .timerStart(timerStart)
);

// File: tb/wp_cmd_sequencer_tb.sv
module wp_cmd_sequencer_tb_top;

  typedef struct packed {
    logic [3:0]  req;
    logic        v;
    logic [14:0] a;
    logic [7:0]  d;
    logic        to;
    logic        done;
    logic        ePass;
    logic        eTmr;
    logic        eProt;
  } vec_t;

  localparam int NV = 51;
  // req, valid, addr, data, timeout, done | expPass, expTimer, expProt
  localparam vec_t VECS [NV] = '{
    '{4'd1, 1'b0, 15'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 idle
    '{4'd2, 1'b1, 15'h1234, 8'h5A, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 plain write
    '{4'd2, 1'b1, 15'h1235, 8'h5B, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 second byte
    '{4'd2, 1'b0, 15'h0000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd2, 1'b1, 15'h0100, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // busy ignore
    '{4'd2, 1'b0, 15'h0000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{4'd3, 1'b1, 15'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 key
    '{4'd3, 1'b1, 15'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd3, 1'b1, 15'h5555, 8'hA0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd3, 1'b1, 15'h0040, 8'hC3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{4'd3, 1'b0, 15'h0000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd3, 1'b0, 15'h0000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{4'd3, 1'b0, 15'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 set
    '{4'd5, 1'b1, 15'h0040, 8'h77, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R5 reject
    '{4'd5, 1'b1, 15'h0041, 8'h78, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R5 ignored
    '{4'd5, 1'b0, 15'h0000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{4'd6, 1'b1, 15'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 key
    '{4'd6, 1'b1, 15'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{4'd6, 1'b1, 15'h5555, 8'hA0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{4'd6, 1'b1, 15'h0080, 8'h01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{4'd6, 1'b1, 15'h0081, 8'h02, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{4'd6, 1'b0, 15'h0000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{4'd6, 1'b0, 15'h0000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{4'd8, 1'b1, 15'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R8
    '{4'd8, 1'b1, 15'h2AAB, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R8 break
    '{4'd8, 1'b0, 15'h0000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{4'd10, 1'b1, 15'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R10
    '{4'd10, 1'b0, 15'h0000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{4'd10, 1'b1, 15'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R10 fresh
    '{4'd10, 1'b0, 15'h0000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{4'd7, 1'b1, 15'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 release
    '{4'd7, 1'b1, 15'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{4'd7, 1'b1, 15'h5555, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{4'd7, 1'b1, 15'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{4'd7, 1'b1, 15'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{4'd7, 1'b1, 15'h5555, 8'h20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{4'd7, 1'b1, 15'h0200, 8'h9C, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{4'd7, 1'b0, 15'h0000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{4'd7, 1'b0, 15'h0000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{4'd7, 1'b0, 15'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 cleared
    '{4'd9, 1'b1, 15'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R9
    '{4'd9, 1'b1, 15'h2AAA, 8'h56, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R9 passes
    '{4'd9, 1'b0, 15'h0000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd9, 1'b0, 15'h0000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{4'd9, 1'b0, 15'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd4, 1'b1, 15'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4
    '{4'd4, 1'b1, 15'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd4, 1'b1, 15'h5555, 8'hA0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd4, 1'b0, 15'h0000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd4, 1'b0, 15'h0000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{4'd4, 1'b0, 15'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}  // R4 set
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic protClr = 1'b1;
  logic wrValid = 1'b0;
  logic [14:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic loadTimeout = 1'b0;
  logic writeDone = 1'b0;
  logic protOn, dataPass, timerStart;

  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;  // 125 MHz

  wp_cmd_sequencer dut_i (
    .clk(clk), .rstN(rstN), .protClr(protClr), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData), .loadTimeout(loadTimeout),
    .writeDone(writeDone), .protOn(protOn), .dataPass(dataPass),
    .timerStart(timerStart)
  );

  task automatic check(input int req, input logic ePass, input logic eTmr,
                       input logic eProt);
    nChecks++;
    if (dataPass !== ePass || timerStart !== eTmr || protOn !== eProt) begin
      nFails++;
      $display("FAIL R%0d: pass/timer/prot actual=%b%b%b expected=%b%b%b",
               req, dataPass, timerStart, protOn, ePass, eTmr, eProt);
    end
  endtask

  task automatic drive(input logic v, input logic [14:0] a, input logic [7:0] d,
                       input logic to, input logic done);
    @(negedge clk);
    wrValid = v; wrAddr = a; wrData = d; loadTimeout = to; writeDone = done;
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual=hung expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1; protClr = 1'b0;
    #2 check(1, 1'b0, 1'b0, 1'b0);

    foreach (VECS[i]) begin
      drive(VECS[i].v, VECS[i].a, VECS[i].d, VECS[i].to, VECS[i].done);
      check(int'(VECS[i].req), VECS[i].ePass, VECS[i].eTmr, VECS[i].eProt);
    end

    // R6: protected, key then a full 64-byte page
    drive(1'b1, 15'h5555, 8'hAA, 1'b0, 1'b0); check(6, 1'b0, 1'b0, 1'b1);
    drive(1'b1, 15'h2AAA, 8'h55, 1'b0, 1'b0); check(6, 1'b0, 1'b0, 1'b1);
    drive(1'b1, 15'h5555, 8'hA0, 1'b0, 1'b0); check(6, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 64; k++) begin
      drive(1'b1, 15'h0300 + 15'(k), 8'(k), 1'b0, 1'b0);
      check(6, 1'b1, 1'b0, 1'b1);
    end
    drive(1'b0, '0, '0, 1'b1, 1'b0); check(6, 1'b0, 1'b0, 1'b1);
    drive(1'b0, '0, '0, 1'b0, 1'b1); check(6, 1'b0, 1'b0, 1'b1);
    drive(1'b0, '0, '0, 1'b0, 1'b0); check(6, 1'b0, 1'b0, 1'b1);

    // R11: sequencer reset keeps the flag
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    #2 check(11, 1'b0, 1'b0, 1'b1);
    rstN = 1'b1;
    drive(1'b0, '0, '0, 1'b0, 1'b0); check(11, 1'b0, 1'b0, 1'b1);
    // R11: after reset a plain write is still rejected
    drive(1'b1, 15'h0010, 8'h33, 1'b0, 1'b0); check(11, 1'b0, 1'b1, 1'b1);
    drive(1'b0, '0, '0, 1'b0, 1'b1); check(11, 1'b0, 1'b0, 1'b1);
    // R11: clear input forces flag off next cycle
    @(negedge clk); writeDone = 1'b0; protClr = 1'b1;
    @(negedge clk); protClr = 1'b0;
    #2 check(11, 1'b0, 1'b0, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule